// File: doc/BRIEF.md
# Three-wire serial EEPROM slave

This block models a small non-volatile word store of 64 words by 16 bits. A host reaches it through a chip select, a shift clock, a serial data input and a serial data output. All four pins are sampled in the block's own clock domain. A synchronizer chain feeds edge detectors, so the shift clock must stay well below the system clock. A command opens with a 1 bit after chip select goes high. Two opcode bits follow, then six address bits, and for some commands a 16-bit data word.

Reading works at any time. Every command that changes the array is gated by a programming-enable flag, and two commands under the shared opcode 00 set and clear that flag. An accepted programming command starts a timed cycle when chip select falls. The length of that cycle is a parameter counted in system clocks, and the array is updated when the cycle ends. When chip select is raised again after such a cycle has started, the output pin shows busy as 0 and ready as 1. No new command is decoded while the cycle runs.

The output pin is modelled as a data bit plus a drive-enable bit. When the enable is low the pin is at high impedance.

Top module: `ee3w_slave`

## Requirements
- R1: After reset the output enable is low, the programming-enable flag is clear and every word reads as 16'hFFFF.
- R2: READ (opcode 10) drives one 0 bit after the last address bit, then the addressed word MSB first. A new bit appears after each rising shift-clock edge.
- R3: WRITE (opcode 01) with the enable flag set stores the 16 data bits that follow the address into the addressed word. No erase is needed first.
- R4: With the enable flag clear, WRITE, ERASE, erase-all and write-all change no word and start no timed cycle. The output stays undriven when chip select is raised again.
- R5: ERASE (opcode 11) with the enable flag set makes the addressed word 16'hFFFF.
- R6: Erase-all (opcode 00, address bits [5:4] = 10) with the enable flag set makes every word 16'hFFFF.
- R7: Write-all (opcode 00, address bits [5:4] = 01, then 16 data bits) with the enable flag set stores the data word in every location.
- R8: Opcode 00 with address bits [5:4] = 11 sets the enable flag. With [5:4] = 00 it clears the flag. The low four address bits are ignored.
- R9: After a timed cycle starts, raising chip select drives the output at 0 while busy and at 1 once ready. The cycle lasts PROG_CYCLES system clocks.
- R10: Shift-clock traffic while a timed cycle is busy is ignored: no command is decoded and no word changes.
- R11: While chip select is low the output is undriven. Leading 0 bits before the start bit are skipped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial shift clock |
| di | input | 1 | Serial data in |
| dout | output | 1 | Serial data out value |
| dout_en | output | 1 | Output drive enable (0 = high impedance) |

## Verification
A decode state that is off by one bit position corrupts the first READ that follows. The dummy bit or one of the next 16 bits comes out wrong within a single command. A wrong enable flag or a lost pending command shows up on the next chip-select rise as missing or unexpected busy status, and as a bad word on the next read. A timer that never expires keeps the output at 0 well past PROG_CYCLES. The bench polls for ready within a bound and reports that case.

// File: rtl/ee3w_pkg.sv
package ee3w_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_HOLD
    } state_e;

    typedef enum logic [2:0] {
        PG_NONE,
        PG_WORD,
        PG_CLEAR,
        PG_CLEAR_ALL,
        PG_FILL_ALL
    } prog_e;

    localparam logic [1:0] OPC_SPECIAL = 2'b00;
    localparam logic [1:0] OPC_WRITE   = 2'b01;
    localparam logic [1:0] OPC_READ    = 2'b10;
    localparam logic [1:0] OPC_ERASE   = 2'b11;

    localparam logic [1:0] SUB_LOCK     = 2'b00;
    localparam logic [1:0] SUB_FILL     = 2'b01;
    localparam logic [1:0] SUB_CLEARALL = 2'b10;
    localparam logic [1:0] SUB_UNLOCK   = 2'b11;
endpackage

// File: rtl/ee3w_pin_sync.sv
module ee3w_pin_sync #(
    parameter int STAGES = 2,
    parameter int N      = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] chain_q [STAGES];
    logic [N-1:0] prev_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[0] <= '0;
                else        chain_q[0] <= pin_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign rise_o = chain_q[STAGES-1] & ~prev_q;
    assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/ee3w_prog_timer.sv
module ee3w_prog_timer #(
    parameter int CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i && cnt_q == '0) cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)       cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
    assign done_o = (cnt_q == CW'(1));
endmodule

// File: rtl/ee3w_word_store.sv
module ee3w_word_store #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [WORD_W-1:0] rd_data_o,
    input  logic              wr_one_i,
    input  logic              wr_all_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [WORD_W-1:0] wr_data_i
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem_q [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[w] <= '1;
            end else if (wr_all_i || (wr_one_i && wr_addr_i == ADDR_W'(w))) begin
                mem_q[w] <= wr_data_i;
            end
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/ee3w_slave.sv
module ee3w_slave #(
    parameter int ADDR_W      = 6,
    parameter int WORD_W      = 16,
    parameter int PROG_CYCLES = 250000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic dout,
    output logic dout_en
);
    import ee3w_pkg::*;

    localparam int LONGEST = (WORD_W > ADDR_W) ? WORD_W : ADDR_W;
    localparam int CNT_W   = $clog2(LONGEST);
    localparam int P_CS    = 0;
    localparam int P_SK    = 1;
    localparam int P_DI    = 2;

    typedef struct packed {
        state_e            state;
        logic [1:0]        opc;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
        logic [WORD_W:0]   out_sr;
        logic [CNT_W-1:0]  cnt;
        prog_e             op;
        logic              latch;
        logic              armed;
        logic              show;
        logic              stat_pend;
    } regs_t;

    regs_t r_d, r_q;

    logic [2:0] pin_lvl, pin_rise, pin_fall;
    logic       cs_lvl, cs_rise, cs_fall, sk_rise, di_lvl;
    logic       prog_busy, prog_done, launch;
    logic [ADDR_W-1:0] rd_addr, full_addr;
    logic [WORD_W-1:0] rd_word, wr_data;
    logic       wr_one, wr_all;
    logic       rd_active, decoding;

    ee3w_pin_sync #(
        .STAGES (SYNC_STAGES),
        .N      (3)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({di, sk, cs}),
        .lvl_o  (pin_lvl),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    assign cs_lvl  = pin_lvl[P_CS];
    assign cs_rise = pin_rise[P_CS];
    assign cs_fall = pin_fall[P_CS];
    assign sk_rise = pin_rise[P_SK];
    assign di_lvl  = pin_lvl[P_DI];

    ee3w_prog_timer #(
        .CYCLES  (PROG_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (launch),
        .busy_o  (prog_busy),
        .done_o  (prog_done)
    );

    assign full_addr = {r_q.addr[ADDR_W-2:0], di_lvl};
    assign rd_addr   = full_addr;

    ee3w_word_store #(
        .ADDR_W    (ADDR_W),
        .WORD_W    (WORD_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_word),
        .wr_one_i  (wr_one),
        .wr_all_i  (wr_all),
        .wr_addr_i (r_q.addr),
        .wr_data_i (wr_data)
    );

    // Commit of a pending programming command when the timed cycle expires
    assign wr_one  = prog_done && (r_q.op == PG_WORD || r_q.op == PG_CLEAR);
    assign wr_all  = prog_done && (r_q.op == PG_CLEAR_ALL || r_q.op == PG_FILL_ALL);
    assign wr_data = (r_q.op == PG_CLEAR || r_q.op == PG_CLEAR_ALL) ? '1 : r_q.data;

    always_comb begin
        r_d    = r_q;
        launch = 1'b0;

        if (!cs_lvl) begin
            r_d.state = ST_IDLE;
        end

        if (cs_fall) begin
            if (r_q.armed && !prog_busy) begin
                launch        = 1'b1;
                r_d.stat_pend = 1'b1;
            end else if (r_q.show && !prog_busy) begin
                r_d.stat_pend = 1'b0;
            end
            r_d.armed = 1'b0;
            r_d.show  = 1'b0;
        end

        if (cs_rise && r_q.stat_pend) begin
            r_d.show = 1'b1;
        end

        if (cs_lvl && sk_rise) begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (di_lvl && !prog_busy) begin
                        r_d.state     = ST_OPC;
                        r_d.cnt       = '0;
                        r_d.show      = 1'b0;
                        r_d.stat_pend = 1'b0;
                        r_d.op        = PG_NONE;
                    end
                end
                ST_OPC: begin
                    r_d.opc = {r_q.opc[0], di_lvl};
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == CNT_W'(1)) begin
                        r_d.state = ST_ADDR;
                        r_d.cnt   = '0;
                    end
                end
                ST_ADDR: begin
                    r_d.addr = full_addr;
                    r_d.cnt  = r_q.cnt + 1'b1;
                    if (r_q.cnt == CNT_W'(ADDR_W - 1)) begin
                        r_d.cnt   = '0;
                        r_d.state = ST_HOLD;
                        unique case (r_q.opc)
                            OPC_READ: begin
                                r_d.state  = ST_READ;
                                r_d.out_sr = {1'b0, rd_word};
                            end
                            OPC_WRITE: begin
                                r_d.state = ST_DATA;
                                r_d.op    = PG_WORD;
                            end
                            OPC_ERASE: begin
                                r_d.op    = PG_CLEAR;
                                r_d.armed = r_q.latch;
                            end
                            default: begin
                                unique case (full_addr[ADDR_W-1 -: 2])
                                    SUB_UNLOCK:   r_d.latch = 1'b1;
                                    SUB_LOCK:     r_d.latch = 1'b0;
                                    SUB_CLEARALL: begin
                                        r_d.op    = PG_CLEAR_ALL;
                                        r_d.armed = r_q.latch;
                                    end
                                    default: begin
                                        r_d.op    = PG_FILL_ALL;
                                        r_d.state = ST_DATA;
                                    end
                                endcase
                            end
                        endcase
                    end
                end
                ST_DATA: begin
                    r_d.data = {r_q.data[WORD_W-2:0], di_lvl};
                    r_d.cnt  = r_q.cnt + 1'b1;
                    if (r_q.cnt == CNT_W'(WORD_W - 1)) begin
                        r_d.state = ST_HOLD;
                        r_d.armed = r_q.latch;
                    end
                end
                ST_READ: begin
                    r_d.out_sr = {r_q.out_sr[WORD_W-1:0], 1'b0};
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, op: PG_NONE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_active = (r_q.state == ST_READ);
    assign decoding  = (r_q.state == ST_OPC);
    assign dout_en   = cs_lvl && (r_q.show || rd_active);
    assign dout      = r_q.show ? !prog_busy : r_q.out_sr[WORD_W];
endmodule

// File: rtl/ee3w_slave_chk.sv
module ee3w_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic commit,
    input logic latch,
    input logic reading,
    input logic decoding,
    input logic dout
);
    // R4: a timed cycle only starts while programming is enabled
    p_launch_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> latch);

    // R3: the busy period ends right after the commit pulse
    p_busy_ends_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(commit));

    // R3: one commit per timed cycle
    p_commit_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // R10: no opcode decoding while busy
    p_no_decode_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !decoding);

    // R2: the first bit of a read is the zero dummy bit
    p_dummy_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reading) |-> !dout);
endmodule

bind ee3w_slave ee3w_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (prog_busy),
    .commit   (prog_done),
    .latch    (r_q.latch),
    .reading  (rd_active),
    .decoding (decoding),
    .dout     (dout)
);

// File: tb/test_ee3w_slave.sv
module test_ee3w_slave;
    localparam int ADDR_W = 6;
    localparam int WORD_W = 16;
    localparam int PROG   = 600;
    localparam int NVEC   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic dout, dout_en;
    int   n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    ee3w_slave #(
        .ADDR_W      (ADDR_W),
        .WORD_W      (WORD_W),
        .PROG_CYCLES (PROG),
        .SYNC_STAGES (2)
    ) i_ee3w_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (cs),
        .sk      (sk),
        .di      (di),
        .dout    (dout),
        .dout_en (dout_en)
    );

    // {req[5:0], opc[1:0], addr[5:0], data[15:0], expect[15:0], is_read, expect_busy}
    localparam logic [47:0] VEC [NVEC] = '{
        {6'd8,  2'b00, 6'b110101, 16'h0000, 16'h0000, 1'b0, 1'b0}, // R8 enable
        {6'd3,  2'b01, 6'd5,      16'hA5C3, 16'h0000, 1'b0, 1'b1}, // R3 write
        {6'd3,  2'b10, 6'd5,      16'h0000, 16'hA5C3, 1'b1, 1'b0}, // R3 readback
        {6'd3,  2'b01, 6'd63,     16'h1234, 16'h0000, 1'b0, 1'b1}, // R3 top address
        {6'd2,  2'b10, 6'd63,     16'h0000, 16'h1234, 1'b1, 1'b0}, // R2 read
        {6'd5,  2'b11, 6'd5,      16'h0000, 16'h0000, 1'b0, 1'b1}, // R5 erase
        {6'd5,  2'b10, 6'd5,      16'h0000, 16'hFFFF, 1'b1, 1'b0}, // R5 check
        {6'd8,  2'b00, 6'b001010, 16'h0000, 16'h0000, 1'b0, 1'b0}, // R8 disable
        {6'd4,  2'b01, 6'd7,      16'hBEEF, 16'h0000, 1'b0, 1'b0}, // R4 blocked write
        {6'd4,  2'b10, 6'd7,      16'h0000, 16'hFFFF, 1'b1, 1'b0}, // R4 unchanged
        {6'd4,  2'b00, 6'b100000, 16'h0000, 16'h0000, 1'b0, 1'b0}, // R4 blocked erase-all
        {6'd4,  2'b10, 6'd63,     16'h0000, 16'h1234, 1'b1, 1'b0}, // R4 unchanged
        {6'd8,  2'b00, 6'b111111, 16'h0000, 16'h0000, 1'b0, 1'b0}, // R8 enable again
        {6'd7,  2'b00, 6'b010011, 16'h0F0F, 16'h0000, 1'b0, 1'b1}, // R7 write-all
        {6'd7,  2'b10, 6'd40,     16'h0000, 16'h0F0F, 1'b1, 1'b0}, // R7 check
        {6'd6,  2'b00, 6'b101100, 16'h0000, 16'h0000, 1'b0, 1'b1}  // R6 erase-all
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic b);
        di = b;
        wait_clk(2);
        sk = 1'b1;
        wait_clk(4);
        sk = 1'b0;
        wait_clk(4);
    endtask

    task automatic send_cmd(input logic [1:0] opc, input logic [5:0] addr,
                            input logic [15:0] data, input int lead0);
        for (int i = 0; i < lead0; i++) pulse(1'b0);
        pulse(1'b1);
        for (int i = 1; i >= 0; i--) pulse(opc[i]);
        for (int i = 5; i >= 0; i--) pulse(addr[i]);
        if (opc == 2'b01 || (opc == 2'b00 && addr[5:4] == 2'b01))
            for (int i = 15; i >= 0; i--) pulse(data[i]);
    endtask

    task automatic do_read(input string req, input logic [5:0] addr,
                           input logic [15:0] exp, input int lead0);
        logic [15:0] got;
        cs = 1'b1;
        wait_clk(4);
        send_cmd(2'b10, addr, 16'h0, lead0);
        check({req, " dummy"}, {dout_en, dout}, 2'b10);
        for (int i = 15; i >= 0; i--) begin
            pulse(1'b0);
            got[i] = dout;
        end
        check(req, got, exp);
        cs = 1'b0;
        wait_clk(6);
    endtask

    task automatic wait_ready(input string req);
        int t;
        t = 0;
        while (dout !== 1'b1 && t < PROG + 100) begin
            wait_clk(1);
            t++;
        end
        check({req, " ready"}, {dout_en, dout}, 2'b11);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R1: reset state
        check("R1 dout_en", dout_en, 1'b0);
        do_read("R1", 6'd0, 16'hFFFF, 0);
        cs = 1'b1; wait_clk(2);
        send_cmd(2'b11, 6'd1, 16'h0, 0);
        cs = 1'b0; wait_clk(6);
        cs = 1'b1; wait_clk(8);
        check("R1 latch clear", dout_en, 1'b0);
        cs = 1'b0; wait_clk(6);

        for (int v = 0; v < NVEC; v++) begin
            string req;
            req = $sformatf("R%0d", VEC[v][47:42]);
            if (VEC[v][1]) begin
                do_read(req, VEC[v][39:34], VEC[v][17:2], 0);
            end else begin
                cs = 1'b1; wait_clk(2);
                send_cmd(VEC[v][41:40], VEC[v][39:34], VEC[v][33:18], 0);
                cs = 1'b0; wait_clk(6);
                cs = 1'b1; wait_clk(8);
                if (VEC[v][0]) begin
                    // R9: busy shown as 0, then ready as 1
                    check({req, " R9 busy"}, {dout_en, dout}, 2'b10);
                    wait_ready({req, " R9"});
                end else begin
                    check({req, " undriven"}, dout_en, 1'b0);
                end
                cs = 1'b0; wait_clk(6);
            end
        end

        // R6: erase-all reached every word
        do_read("R6", 6'd63, 16'hFFFF, 0);
        // R11: leading zeros skipped, output undriven with cs low
        do_read("R11 leading zeros", 6'd40, 16'hFFFF, 3);
        check("R11 hi-z", dout_en, 1'b0);

        // R10: commands during busy are ignored
        cs = 1'b1; wait_clk(2);
        send_cmd(2'b01, 6'd9, 16'h1111, 0);
        cs = 1'b0; wait_clk(6);
        cs = 1'b1; wait_clk(8);
        send_cmd(2'b01, 6'd10, 16'h2222, 0);
        check("R10 status held", {dout_en, dout}, 2'b10);
        wait_ready("R10");
        cs = 1'b0; wait_clk(6);
        cs = 1'b1; wait_clk(8);
        check("R10 no second cycle", dout_en, 1'b0);
        cs = 1'b0; wait_clk(6);
        do_read("R10 ignored write", 6'd10, 16'hFFFF, 0);
        do_read("R3 first write", 6'd9, 16'h1111, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule